// File: doc/BRIEF.md
# On-Demand External Transfer Request Controller

This block connects an external requesting device to a four-channel DMA engine. While its enable input is set, it turns external requests into queued per-channel transfer requests. A request arrives in one of three ways. The first is a bus handshake: the device asks for the bus, the block obtains a grant from the bus controller, and the block then reads a request word off the shared data bus. The second is a strobe-only request that never touches the bus. The third is a shortcut that serves the fixed channel 2 when the bus request and the strobe arrive together.

Accepted requests wait in a small FIFO. The DMA engine takes them from the head with a valid/accept pair. Each accepted request produces a one-cycle acknowledge that carries the channel number. While the enable is clear, the block only forwards the ordinary per-channel request lines, each delayed by one register. Clearing the enable empties the queue and stops any handshake in progress.

Top module: `ondemand_req_ctrl`

## Requirements
- R1: With `od_enable` low, `chan_req` equals `ext_chan_req` of the previous cycle, and `xstrobe` and `xreq_bus` have no effect: `bus_req` stays low and `dma_valid` stays low. With `od_enable` high, `chan_req` is zero one cycle later.
- R2: In the idle state, `xreq_bus` high with `xstrobe` low raises `bus_req` on the next cycle. `bus_avail` rises only in the cycle after a clock edge at which `bus_grant` was high.
- R3: When `xstrobe` is high while `bus_avail` is high, the request word on `data_bus` is captured. Its channel is taken from bits [1:0] and its mode from bits [4:2]. Both `bus_avail` and `bus_req` are low in the following cycle.
- R4: A captured word is rejected and queues nothing if its mode code is 5, 6 or 7, or if any bit above bit 4 is set. A rejected word does not change the channel and mode remembered for strobe-only requests.
- R5: In the idle state, `xstrobe` high with `xreq_bus` low queues one request per cycle. That request reuses the channel and mode of the last word accepted, which is channel 0, mode 0 after reset.
- R6: In the idle state, `xstrobe` and `xreq_bus` high together queue channel 2 with mode 0 and do not raise `bus_req`.
- R7: The queue holds 4 requests and presents them on `dma_valid`/`dma_chan`/`dma_mode` in arrival order.
- R8: A request that arrives while the queue is full is dropped, and `overflow` is high for exactly the next cycle.
- R9: A clock edge with `dma_valid` and `dma_accept` both high removes the head entry. `ack` is then high for one cycle, and `ack_id` gives the removed entry's channel.
- R10: While `dma_valid` is high and `dma_accept` is low, the head entry stays on the outputs unchanged.
- R11: A clock edge with `od_enable` low empties the queue and returns the handshake to idle. No entry remains once the enable returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| od_enable | input | 1 | On-demand mode enable |
| ext_chan_req | input | NUM_CH | Ordinary per-channel request lines |
| chan_req | output | NUM_CH | Registered per-channel requests to the DMA engine |
| xreq_bus | input | 1 | External device asks for the data bus |
| xstrobe | input | 1 | External transfer-request strobe |
| data_bus | input | DATA_W | Shared data bus carrying the request word |
| bus_req | output | 1 | Bus request to the bus controller |
| bus_grant | input | 1 | Bus grant from the bus controller |
| bus_avail | output | 1 | Tells the device the bus is ready for its word |
| dma_valid | output | 1 | Queue head is valid |
| dma_chan | output | CH_W | Channel of the queue head |
| dma_mode | output | 3 | Transfer mode of the queue head |
| dma_accept | input | 1 | DMA engine takes the queue head |
| ack | output | 1 | One-cycle acknowledge to the device |
| ack_id | output | CH_W | Channel served by the acknowledge |
| overflow | output | 1 | One-cycle pulse when a request is dropped |

## Verification
The bench builds the block with a 16-bit data bus and the default four-entry queue and four channels. The narrow bus keeps the reserved-bit rejection easy to drive. It still leaves room for legal and illegal mode codes in the decoded field. The shallow queue lets a held strobe fill the queue and overflow it within a few cycles. Repeated strobe-only requests and the channel-2 shortcut then show the order of the queue and that the remembered word is reused.

// File: rtl/odr_pkg.sv
package odr_pkg;
  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_REQ   = 2'd1,
    HS_GRANT = 2'd2
  } hs_state_e;

  localparam int MODE_W     = 3;
  localparam int MODE_LIMIT = 5;
endpackage

// File: rtl/od_word_decode.sv
module od_word_decode #(
  parameter int DATA_W     = 64,
  parameter int CH_W       = 2,
  parameter int MODE_W     = 3,
  parameter int MODE_LIMIT = 5
) (
  input  logic [DATA_W-1:0] word,
  output logic [CH_W-1:0]   chan,
  output logic [MODE_W-1:0] mode,
  output logic              legal
);
  localparam int FIELD_W = CH_W + MODE_W;

  logic reserved_clear;

  always_comb begin
    chan           = word[CH_W-1:0];
    mode           = word[FIELD_W-1:CH_W];
    reserved_clear = (word[DATA_W-1:FIELD_W] == '0);
    legal          = reserved_clear && (int'(mode) < MODE_LIMIT);
  end
endmodule

// File: rtl/od_handshake.sv
module od_handshake
  import odr_pkg::*;
#(
  parameter int CH_W     = 2,
  parameter int MODE_W   = 3,
  parameter int SHORT_CH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              xreq_bus,
  input  logic              xstrobe,
  input  logic              bus_grant,
  input  logic [CH_W-1:0]   word_chan,
  input  logic [MODE_W-1:0] word_mode,
  input  logic              word_legal,
  output logic              bus_req,
  output logic              bus_avail,
  output logic              push,
  output logic [CH_W-1:0]   push_chan,
  output logic [MODE_W-1:0] push_mode
);
  hs_state_e         state_q, state_d;
  logic [CH_W-1:0]   last_chan_q;
  logic [MODE_W-1:0] last_mode_q;
  logic              take_word;

  always_comb begin
    state_d   = state_q;
    push      = 1'b0;
    push_chan = last_chan_q;
    push_mode = last_mode_q;
    take_word = 1'b0;
    if (!enable) begin
      state_d = HS_IDLE;
    end else begin
      unique case (state_q)
        HS_IDLE: begin
          if (xstrobe && xreq_bus) begin
            push      = 1'b1;
            push_chan = CH_W'(SHORT_CH);
            push_mode = '0;
          end else if (xstrobe) begin
            push = 1'b1;
          end else if (xreq_bus) begin
            state_d = HS_REQ;
          end
        end
        HS_REQ: begin
          if (bus_grant) state_d = HS_GRANT;
        end
        HS_GRANT: begin
          if (xstrobe) begin
            state_d   = HS_IDLE;
            take_word = word_legal;
            push      = word_legal;
            push_chan = word_chan;
            push_mode = word_mode;
          end
        end
        default: state_d = HS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= HS_IDLE;
      last_chan_q <= '0;
      last_mode_q <= '0;
    end else begin
      state_q <= state_d;
      if (take_word) begin
        last_chan_q <= word_chan;
        last_mode_q <= word_mode;
      end
    end
  end

  assign bus_req   = (state_q != HS_IDLE);
  assign bus_avail = (state_q == HS_GRANT);
endmodule

// File: rtl/od_req_fifo.sv
module od_req_fifo #(
  parameter int WIDTH = 5,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             valid,
  output logic             overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             full, do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign valid   = (count != '0);
  assign do_push = push && !full;
  assign do_pop  = pop && valid;
  assign head    = mem[rd_ptr];

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      overflow <= push && full;
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/ondemand_req_ctrl.sv
module ondemand_req_ctrl
  import odr_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int NUM_CH     = 4,
  parameter int FIFO_DEPTH = 4,
  parameter int SHORT_CH   = 2,
  parameter int CH_W       = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              od_enable,
  input  logic [NUM_CH-1:0] ext_chan_req,
  output logic [NUM_CH-1:0] chan_req,
  input  logic              xreq_bus,
  input  logic              xstrobe,
  input  logic [DATA_W-1:0] data_bus,
  output logic              bus_req,
  input  logic              bus_grant,
  output logic              bus_avail,
  output logic              dma_valid,
  output logic [CH_W-1:0]   dma_chan,
  output logic [MODE_W-1:0] dma_mode,
  input  logic              dma_accept,
  output logic              ack,
  output logic [CH_W-1:0]   ack_id,
  output logic              overflow
);
  localparam int ENT_W = CH_W + MODE_W;

  logic [CH_W-1:0]   word_chan, push_chan;
  logic [MODE_W-1:0] word_mode, push_mode;
  logic              word_legal, push, pop;
  logic [ENT_W-1:0]  head;

  od_word_decode #(
    .DATA_W(DATA_W), .CH_W(CH_W), .MODE_W(MODE_W), .MODE_LIMIT(MODE_LIMIT)
  ) i_decode (
    .word(data_bus), .chan(word_chan), .mode(word_mode), .legal(word_legal)
  );

  od_handshake #(
    .CH_W(CH_W), .MODE_W(MODE_W), .SHORT_CH(SHORT_CH)
  ) i_hs (
    .clk(clk), .rst(rst), .enable(od_enable),
    .xreq_bus(xreq_bus), .xstrobe(xstrobe), .bus_grant(bus_grant),
    .word_chan(word_chan), .word_mode(word_mode), .word_legal(word_legal),
    .bus_req(bus_req), .bus_avail(bus_avail),
    .push(push), .push_chan(push_chan), .push_mode(push_mode)
  );

  assign pop = od_enable && dma_accept;

  od_req_fifo #(
    .WIDTH(ENT_W), .DEPTH(FIFO_DEPTH)
  ) i_fifo (
    .clk(clk), .rst(rst), .flush(!od_enable),
    .push(push), .push_data({push_mode, push_chan}),
    .pop(pop), .head(head), .valid(dma_valid), .overflow(overflow)
  );

  assign dma_chan = head[CH_W-1:0];
  assign dma_mode = head[ENT_W-1:CH_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_req <= '0;
      ack      <= 1'b0;
      ack_id   <= '0;
    end else begin
      chan_req <= od_enable ? '0 : ext_chan_req;
      ack      <= pop && dma_valid;
      if (pop && dma_valid) ack_id <= dma_chan;
    end
  end
endmodule

// File: rtl/odr_checker.sv
module odr_checker #(
  parameter int CH_W   = 2,
  parameter int MODE_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              od_enable,
  input logic              bus_req,
  input logic              bus_grant,
  input logic              bus_avail,
  input logic              xstrobe,
  input logic              dma_valid,
  input logic [CH_W-1:0]   dma_chan,
  input logic [MODE_W-1:0] dma_mode,
  input logic              dma_accept,
  input logic              ack,
  input logic [CH_W-1:0]   ack_id,
  input logic              overflow
);
  // R2
  grant_before_avail_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_avail) |-> $past(bus_grant));

  // R3
  release_after_word_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_avail) |-> ($past(xstrobe) || !$past(od_enable)) && !bus_req);

  // R8
  overflow_needs_entries_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |-> $past(dma_valid));

  // R9
  ack_follows_accept_chk: assert property (@(posedge clk) disable iff (rst)
    ack |-> $past(dma_valid && dma_accept) && ack_id == $past(dma_chan));

  // R10
  head_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dma_valid && !dma_accept && od_enable) |=>
      dma_valid && $stable(dma_chan) && $stable(dma_mode));

  // R11
  disable_clears_chk: assert property (@(posedge clk) disable iff (rst)
    !od_enable |=> !dma_valid && !bus_req && !bus_avail);
endmodule

bind ondemand_req_ctrl odr_checker #(.CH_W(CH_W), .MODE_W(odr_pkg::MODE_W)) i_odr_checker (
  .clk(clk), .rst(rst), .od_enable(od_enable), .bus_req(bus_req),
  .bus_grant(bus_grant), .bus_avail(bus_avail), .xstrobe(xstrobe),
  .dma_valid(dma_valid), .dma_chan(dma_chan), .dma_mode(dma_mode),
  .dma_accept(dma_accept), .ack(ack), .ack_id(ack_id), .overflow(overflow)
);

// File: tb/test_ondemand_req_ctrl.sv
module test_ondemand_req_ctrl;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          od_enable = 1'b0;
  logic [3:0]    ext_chan_req = '0;
  logic [3:0]    chan_req;
  logic          xreq_bus = 1'b0, xstrobe = 1'b0, bus_grant = 1'b0, dma_accept = 1'b0;
  logic [DW-1:0] data_bus = '0;
  logic          bus_req, bus_avail, dma_valid, ack, overflow;
  logic [1:0]    dma_chan, ack_id;
  logic [2:0]    dma_mode;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  ondemand_req_ctrl #(.DATA_W(DW), .NUM_CH(4), .FIFO_DEPTH(4)) i_ondemand_req_ctrl (
    .clk(clk), .rst(rst), .od_enable(od_enable), .ext_chan_req(ext_chan_req),
    .chan_req(chan_req), .xreq_bus(xreq_bus), .xstrobe(xstrobe), .data_bus(data_bus),
    .bus_req(bus_req), .bus_grant(bus_grant), .bus_avail(bus_avail),
    .dma_valid(dma_valid), .dma_chan(dma_chan), .dma_mode(dma_mode),
    .dma_accept(dma_accept), .ack(ack), .ack_id(ack_id), .overflow(overflow)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // pops the head, checking its content and the acknowledge (R9)
  task automatic pop_expect(input int ch, input int md, input string req);
    check(dma_valid == 1'b1, req, dma_valid, 1);
    check(dma_chan == 2'(ch), req, dma_chan, ch);
    check(dma_mode == 3'(md), req, dma_mode, md);
    dma_accept = 1'b1;
    tick();
    dma_accept = 1'b0;
    check(ack == 1'b1, "R9", ack, 1);
    check(ack_id == 2'(ch), "R9", ack_id, ch);
    tick();
    check(ack == 1'b0, "R9", ack, 0);
  endtask

  // full bus handshake carrying a request word
  task automatic word_req(input logic [DW-1:0] word);
    xreq_bus = 1'b1;
    tick();
    xreq_bus = 1'b0;
    check(bus_req == 1'b1, "R2", bus_req, 1);
    check(bus_avail == 1'b0, "R2", bus_avail, 0);
    tick();
    check(bus_avail == 1'b0, "R2", bus_avail, 0);
    bus_grant = 1'b1;
    tick();
    bus_grant = 1'b0;
    check(bus_avail == 1'b1, "R2", bus_avail, 1);
    xstrobe  = 1'b1;
    data_bus = word;
    tick();
    xstrobe  = 1'b0;
    data_bus = '0;
    check(bus_avail == 1'b0, "R3", bus_avail, 0);
    check(bus_req == 1'b0, "R3", bus_req, 0);
  endtask

  task automatic strobe_only(input int n);
    xstrobe = 1'b1;
    repeat (n) tick();
    xstrobe = 1'b0;
  endtask

  task automatic t_reset_and_disabled();
    check(bus_req == 0 && bus_avail == 0 && dma_valid == 0 && ack == 0 && overflow == 0,
          "R1", {bus_req, bus_avail, dma_valid, ack, overflow}, 0);
    ext_chan_req = 4'b1010;
    xstrobe  = 1'b1;
    xreq_bus = 1'b1;
    tick();
    check(chan_req == 4'b1010, "R1", chan_req, 10);
    check(dma_valid == 1'b0, "R1", dma_valid, 0);
    check(bus_req == 1'b0, "R1", bus_req, 0);
    xstrobe = 1'b0;
    xreq_bus = 1'b0;
    od_enable = 1'b1;
    tick();
    check(chan_req == 4'b0000, "R1", chan_req, 0);
    check(dma_valid == 1'b0, "R1", dma_valid, 0);
    ext_chan_req = '0;
  endtask

  task automatic t_strobe_after_reset();
    strobe_only(1);
    pop_expect(0, 0, "R5");
  endtask

  task automatic t_order_and_hold();
    word_req(16'((2 << 2) | 1));
    word_req(16'((4 << 2) | 3));
    strobe_only(1);
    xreq_bus = 1'b1;
    xstrobe  = 1'b1;
    tick();
    xreq_bus = 1'b0;
    xstrobe  = 1'b0;
    check(bus_req == 1'b0, "R6", bus_req, 0);
    repeat (3) begin
      tick();
      check(dma_chan == 2'd1 && dma_mode == 3'd2, "R10", dma_chan, 1);
    end
    pop_expect(1, 2, "R7");
    pop_expect(3, 4, "R7");
    pop_expect(3, 4, "R5");
    pop_expect(2, 0, "R6");
    check(dma_valid == 1'b0, "R7", dma_valid, 0);
  endtask

  task automatic t_reject();
    word_req(16'((6 << 2) | 2));
    check(dma_valid == 1'b0, "R4", dma_valid, 0);
    word_req(16'h0020 | 16'((1 << 2) | 1));
    check(dma_valid == 1'b0, "R4", dma_valid, 0);
    strobe_only(1);
    pop_expect(3, 4, "R4");
  endtask

  task automatic t_overflow();
    xstrobe = 1'b1;
    repeat (4) tick();
    check(overflow == 1'b0, "R8", overflow, 0);
    tick();
    xstrobe = 1'b0;
    check(overflow == 1'b1, "R8", overflow, 1);
    tick();
    check(overflow == 1'b0, "R8", overflow, 0);
    for (int i = 0; i < 4; i++) pop_expect(3, 4, "R7");
    check(dma_valid == 1'b0, "R8", dma_valid, 0);
  endtask

  task automatic t_disable_flush();
    strobe_only(2);
    xreq_bus = 1'b1;
    tick();
    xreq_bus = 1'b0;
    check(bus_req == 1'b1, "R11", bus_req, 1);
    check(dma_valid == 1'b1, "R11", dma_valid, 1);
    od_enable = 1'b0;
    tick();
    check(dma_valid == 1'b0, "R11", dma_valid, 0);
    check(bus_req == 1'b0, "R11", bus_req, 0);
    od_enable = 1'b1;
    tick();
    check(dma_valid == 1'b0, "R11", dma_valid, 0);
    check(bus_req == 1'b0, "R11", bus_req, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    tick();
    t_reset_and_disabled();
    t_strobe_after_reset();
    t_order_and_hold();
    t_reject();
    t_overflow();
    t_disable_flush();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule